// File: doc/BRIEF.md
# Transmit FIFO Space Usage Calculator

This block works out how many 32-bit words a multi-buffer transmit packet takes up in the transmit data FIFO. The words are counted from the buffer descriptors alone, so the space can be checked before the data arrives or while it is being written. The FIFO and the data path are not part of the block.

Each buffer is presented as one descriptor. A descriptor gives the start offset in bytes, the payload length in bytes, an end-alignment code, and two flags that mark the first and the last segment of the packet. For each buffer the block reports the words it consumes: one or two command words plus its data words. It also keeps a running total for the packet. When the last segment has been counted, it presents the packet total with a single-cycle strobe.

A synchronous clear input empties the accumulator at any time.

Top module: `txfifo_space_calc`

## Requirements
- R1: Every accepted buffer adds exactly one command word to its count, whatever its flags.
- R2: A buffer whose first-segment flag is set adds one more command word, so its count is data words plus two.
- R3: Whole 32-bit words inside the start offset are not counted. Only the offset modulo 4 bytes is added to the buffer's byte total.
- R4: End padding is the byte count that raises offset plus payload to the next boundary of the selected alignment. The codes are: 0 for 4 bytes, 1 for 16, 2 for 32, and 3, which behaves as 4. Whole words of padding are dropped and the remnant below 4 bytes is kept, so the count does not depend on the alignment code.
- R5: All payload bytes are counted. Data words equal (offset mod 4 + payload + padding remnant) divided by 4, rounded up, which gives 1 word for a 0-byte payload at offset 3.
- R6: buf_valid is high, and buf_words holds that buffer's count, in the cycle after a descriptor is accepted (desc_valid high, clear low).
- R7: run_words is the sum of buffer counts since the packet started. A buffer with the first flag set, or the first buffer after a last segment, a clear or reset, restarts the sum at its own count.
- R8: A buffer with the last flag set raises pkt_done for one cycle, together with its buf_valid. In that cycle pkt_words equals run_words. pkt_words then holds until the next last segment or clear.
- R9: When clear is high, every descriptor in that cycle is ignored. In the next cycle buf_valid and pkt_done are low, and run_words and pkt_words are 0.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Empty accumulator; dominates descriptor |
| desc_valid | input | 1 | Descriptor present this cycle |
| desc_first | input | 1 | Buffer is first segment of packet |
| desc_last | input | 1 | Buffer is last segment of packet |
| desc_offset | input | OFS_W | Data start offset in bytes |
| desc_len | input | LEN_W | Payload length in bytes |
| desc_align | input | 2 | End alignment code (0:4, 1:16, 2:32, 3:4) |
| buf_valid | output | 1 | buf_words valid for the buffer just taken |
| buf_words | output | LEN_W+1 | Words consumed by that buffer |
| run_words | output | TOT_W | Running packet total |
| pkt_done | output | 1 | One-cycle strobe after last segment |
| pkt_words | output | TOT_W | Final packet total, held |

## Verification
The assertions assume that every accepted descriptor is sampled in a single cycle, and that clear overrides a descriptor in the same cycle. They also assume the packet total stays below 2**TOT_W. The stimulus changes inputs only on the falling edge and holds each descriptor for exactly one cycle. Its packets are small, so totals never wrap. Alignment codes 0 to 3 are all driven, including the reserved one.

// File: rtl/txfifo_space_calc.sv
module txfifo_space_calc #(
  parameter int OFS_W = 6,
  parameter int LEN_W = 11,
  parameter int TOT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             desc_valid,
  input  logic             desc_first,
  input  logic             desc_last,
  input  logic [OFS_W-1:0] desc_offset,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [1:0]       desc_align,
  output logic             buf_valid,
  output logic [LEN_W:0]   buf_words,
  output logic [TOT_W-1:0] run_words,
  output logic             pkt_done,
  output logic [TOT_W-1:0] pkt_words
);

  localparam int END_W = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;
  localparam int SUM_W = LEN_W + 3;

  logic [END_W-1:0] end_byte;
  logic [4:0]       align_mask;
  logic [4:0]       pad_bytes;
  logic [SUM_W-1:0] kept_bytes;
  logic [SUM_W-1:0] data_words;
  logic [LEN_W:0]   cur_words;
  logic [TOT_W-1:0] next_total;
  logic             closed;
  logic             take;

  assign take     = desc_valid && !clear;
  assign end_byte = END_W'(desc_offset) + END_W'(desc_len);

  always_comb begin
    case (desc_align)
      2'd1:    align_mask = 5'd15;
      2'd2:    align_mask = 5'd31;
      default: align_mask = 5'd3;
    endcase
  end

  assign pad_bytes  = (5'd0 - end_byte[4:0]) & align_mask;
  assign kept_bytes = SUM_W'(desc_offset[1:0]) + SUM_W'(desc_len) + SUM_W'(pad_bytes[1:0]);
  assign data_words = (kept_bytes + SUM_W'(3)) >> 2;
  assign cur_words  = (LEN_W+1)'(data_words) + (desc_first ? (LEN_W+1)'(2) : (LEN_W+1)'(1));
  assign next_total = (desc_first || closed) ? TOT_W'(cur_words) : run_words + TOT_W'(cur_words);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      buf_valid <= 1'b0;
      buf_words <= '0;
      run_words <= '0;
      pkt_done  <= 1'b0;
      pkt_words <= '0;
      closed    <= 1'b1;
    end else begin
      buf_valid <= desc_valid;
      pkt_done  <= desc_valid && desc_last;
      if (desc_valid) begin
        buf_words <= cur_words;
        run_words <= next_total;
        closed    <= desc_last;
        if (desc_last) pkt_words <= next_total;
      end
    end
  end

  AST_BUF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> buf_valid); // R6
  AST_FIRST_TWO_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
    take && desc_first |=> buf_words >= (LEN_W+1)'(2)); // R2
  AST_ONE_CMD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    take && !desc_first && desc_len == '0 && desc_offset[1:0] == 2'd0 |=> buf_words == (LEN_W+1)'(1)); // R1
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !buf_valid && !pkt_done && run_words == '0 && pkt_words == '0); // R9
  AST_DONE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> buf_valid && pkt_words == run_words); // R8
  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !(desc_valid && desc_last) |=> $stable(pkt_words)); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    take && desc_first |=> run_words == TOT_W'(buf_words)); // R7

endmodule

// File: tb/txfifo_space_calc_test.sv
module txfifo_space_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 6, LEN_W = 11, TOT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic desc_valid = 1'b0, desc_first = 1'b0, desc_last = 1'b0;
  logic [OFS_W-1:0] desc_offset = '0;
  logic [LEN_W-1:0] desc_len = '0;
  logic [1:0] desc_align = '0;
  logic buf_valid, pkt_done;
  logic [LEN_W:0] buf_words;
  logic [TOT_W-1:0] run_words, pkt_words;

  int checks = 0, fails = 0;

  txfifo_space_calc #(.OFS_W(OFS_W), .LEN_W(LEN_W), .TOT_W(TOT_W)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .desc_valid(desc_valid),
    .desc_first(desc_first), .desc_last(desc_last), .desc_offset(desc_offset),
    .desc_len(desc_len), .desc_align(desc_align), .buf_valid(buf_valid),
    .buf_words(buf_words), .run_words(run_words), .pkt_done(pkt_done),
    .pkt_words(pkt_words));

  always #(CLK_PERIOD/2) clk = ~clk;

  // first, last, offset, length, align, expected buffer words, expected running total
  localparam int NV = 8;
  localparam int VEC [NV][7] = '{
    '{1, 0,  7, 79, 1, 23, 23},
    '{0, 0,  0, 15, 1,  5, 28},
    '{0, 1, 10, 17, 1,  6, 34},
    '{1, 1,  4,  1, 2,  3,  3},
    '{1, 1,  3,  0, 0,  3,  3},
    '{1, 0,  0, 64, 1, 18, 18},
    '{0, 1,  1,  2, 2,  2, 20},
    '{1, 1,  8,  5, 3,  4,  4}
  };

  function automatic int ref_words(int first, int ofs, int len, int acode);
    int al, pad;
    al  = (acode == 1) ? 16 : (acode == 2) ? 32 : 4;
    pad = (al - ((ofs + len) % al)) % al;
    return ((ofs % 4) + len + (pad % 4) + 3) / 4 + 1 + (first != 0 ? 1 : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int first, int last, int ofs, int len, int acode, bit clr);
    @(negedge clk);
    desc_valid = 1'b1; desc_first = first[0]; desc_last = last[0];
    desc_offset = OFS_W'(ofs); desc_len = LEN_W'(len); desc_align = acode[1:0];
    clear = clr;
    @(negedge clk);
    desc_valid = 1'b0; desc_first = 1'b0; desc_last = 1'b0; clear = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 buf_valid", int'(buf_valid), 0);
    chk("R10 run_words", int'(run_words), 0);
    chk("R10 pkt_words", int'(pkt_words), 0);
    chk("R10 pkt_done", int'(pkt_done), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);
      chk("R6 buf_valid", int'(buf_valid), 1);
      chk("R1 R2 R3 R5 buf_words", int'(buf_words), VEC[i][5]);
      chk("R5 reference", int'(buf_words), ref_words(VEC[i][0], VEC[i][2], VEC[i][3], VEC[i][4]));
      chk("R7 run_words", int'(run_words), VEC[i][6]);
      chk("R8 pkt_done", int'(pkt_done), VEC[i][1]);
      if (VEC[i][1] != 0) chk("R8 pkt_words", int'(pkt_words), VEC[i][6]);
      @(negedge clk);
      chk("R8 one-cycle strobe", int'(pkt_done), 0);
    end

    // R8: pkt_words held while a new packet accumulates
    send(1, 0, 0, 8, 0, 1'b0);
    chk("R8 hold", int'(pkt_words), 4);
    chk("R7 restart", int'(run_words), 4);

    // R4: alignment code has no effect on the count
    for (int a = 0; a < 4; a++) begin
      send(0, 0, 5, 9, a, 1'b0);
      chk("R4 align invariance", int'(buf_words), 4);
    end

    // R9: clear empties totals, descriptor in same cycle ignored
    send(1, 1, 0, 40, 1, 1'b1);
    chk("R9 buf_valid", int'(buf_valid), 0);
    chk("R9 pkt_done", int'(pkt_done), 0);
    chk("R9 run_words", int'(run_words), 0);
    chk("R9 pkt_words", int'(pkt_words), 0);

    // R7: after clear, a buffer without first flag restarts the sum
    send(0, 1, 2, 6, 0, 1'b0);
    chk("R7 after clear", int'(run_words), 3);
    chk("R1 single cmd", int'(buf_words), 3);
    chk("R8 after clear", int'(pkt_words), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule